// File: doc/BRIEF.md
# Boundary Scan Instruction Decoder

This block sits between the instruction register of a boundary-scan test port and the test data registers. It reads the instruction code that the instruction register currently holds. From it the block chooses which data register sits between TDI and the serial data output: the boundary chain or a one-bit bypass stage. It also sets the boundary cells' mode so that they either pass pin data straight through or drive the pins from their update flip-flops. The capture, shift and update strobes from the port's state machine go to the boundary chain only when the chain is the selected register.

Three public instructions are recognised. External test drives the pins from the boundary cells' update flip-flops, so that board interconnect can be checked. Sample/preload captures live pin values and loads the update flip-flops without driving them onto the pins. Bypass shortens the serial path to a single flip-flop and leaves the pins in normal operation. Any code outside the defined set selects bypass. An active test reset also selects bypass.

All pins are plain control and data lines clocked by the test clock. There is no flow control, because the test port's state machine paces every transfer.

Top module: `bscan_instr_decoder`

## Requirements
- R1: With the 2-bit instruction code, 2'b00 selects external test (`cell_mode`=1, `sel_boundary`=1), 2'b01 selects sample/preload (`cell_mode`=0, `sel_boundary`=1), and 2'b10 and 2'b11 select bypass (`cell_mode`=0, `sel_boundary`=0). These outputs follow the code combinationally.
- R2: While `trst_n` is low, the decoder behaves as under bypass whatever the code is. The bypass flip-flop is cleared asynchronously, so `dr_tdo` reads 0.
- R3: Under bypass, a rising `tck` with `capture_dr` high loads 0 into the bypass flip-flop.
- R4: Under bypass, a rising `tck` with `shift_dr` high and `capture_dr` low loads `tdi` into the bypass flip-flop. `dr_tdo` then shows that bit until the next load, so each TDI bit appears at `dr_tdo` one clock later.
- R5: When `capture_dr` and `shift_dr` are both high on the same edge, the capture wins and the bypass flip-flop loads 0.
- R6: When neither `capture_dr` nor `shift_dr` is high, the bypass flip-flop keeps its value.
- R7: `bnd_capture`, `bnd_shift` and `bnd_update` equal `capture_dr`, `shift_dr` and `update_dr` while the boundary chain is selected. They are all 0 under bypass.
- R8: While the boundary chain is selected, `dr_tdo` equals `chain_tail` combinationally.
- R9: Under sample/preload, `update_dr` reaches `bnd_update` while `cell_mode` stays 0, so the preloaded values are not driven to the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test reset, active low, asynchronous |
| ir_code | input | IR_W (2) | Instruction code held in the instruction register |
| tdi | input | 1 | Serial test data in |
| capture_dr | input | 1 | Capture strobe from the state machine |
| shift_dr | input | 1 | Shift strobe from the state machine |
| update_dr | input | 1 | Update strobe from the state machine |
| chain_tail | input | 1 | Serial output of the last boundary cell |
| cell_mode | output | 1 | 1: boundary cells drive from update flip-flops |
| sel_boundary | output | 1 | 1: boundary chain is the active data register |
| bnd_capture | output | 1 | Capture enable to the boundary chain |
| bnd_shift | output | 1 | Shift enable to the boundary chain |
| bnd_update | output | 1 | Update enable to the boundary chain |
| dr_tdo | output | 1 | Serial data-register output |

## Verification
The clocked properties assume that the instruction code and the strobes change only away from the rising test clock. They also assume the code is stable across any edge at which the bypass flip-flop is checked. The bench drives every input on the falling edge, so each code and strobe is settled for half a period before the rising edge. The properties are switched off while the test reset is low, and the bench checks the reset behaviour itself through the outputs.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  typedef enum logic [1:0] {
    OP_EXTEST = 2'd0,
    OP_SAMPLE = 2'd1,
    OP_BYPASS = 2'd2
  } bscan_op_e;
endpackage

// File: rtl/bscan_op_decode.sv
module bscan_op_decode #(
  parameter int IR_W = 2,
  parameter logic [IR_W-1:0] CODE_EXTEST = '0,
  parameter logic [IR_W-1:0] CODE_SAMPLE = IR_W'(1)
) (
  input  logic            trst_n,
  input  logic [IR_W-1:0] ir_code,
  output bscan_pkg::bscan_op_e op
);
  import bscan_pkg::*;

  always_comb begin
    if (!trst_n)                   op = OP_BYPASS;
    else if (ir_code == CODE_EXTEST) op = OP_EXTEST;
    else if (ir_code == CODE_SAMPLE) op = OP_SAMPLE;
    else                           op = OP_BYPASS;
  end
endmodule

// File: rtl/bscan_bypass_stage.sv
module bscan_bypass_stage (
  input  logic tck,
  input  logic trst_n,
  input  logic active,
  input  logic tdi,
  input  logic capture_dr,
  input  logic shift_dr,
  output logic q
);
  logic cap_go, shf_go;
  assign cap_go = active & capture_dr;
  assign shf_go = active & shift_dr & ~capture_dr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     q <= 1'b0;
    else if (cap_go) q <= 1'b0;
    else if (shf_go) q <= tdi;
  end

  assert_capture_zero_R3: assert property (@(posedge tck) disable iff (!trst_n)
    (active && capture_dr) |=> (q == 1'b0));
  assert_shift_tdi_R4: assert property (@(posedge tck) disable iff (!trst_n)
    (active && shift_dr && !capture_dr) |=> (q == $past(tdi)));
  assert_hold_R6: assert property (@(posedge tck) disable iff (!trst_n)
    (!capture_dr && !shift_dr) |=> $stable(q));
endmodule

// File: rtl/bscan_strobe_gate.sv
module bscan_strobe_gate (
  input  logic sel_boundary,
  input  logic capture_dr,
  input  logic shift_dr,
  input  logic update_dr,
  output logic bnd_capture,
  output logic bnd_shift,
  output logic bnd_update
);
  always_comb begin
    bnd_capture = sel_boundary & capture_dr;
    bnd_shift   = sel_boundary & shift_dr;
    bnd_update  = sel_boundary & update_dr;
  end
endmodule

// File: rtl/bscan_instr_decoder.sv
module bscan_instr_decoder #(
  parameter int IR_W = 2
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic [IR_W-1:0] ir_code,
  input  logic            tdi,
  input  logic            capture_dr,
  input  logic            shift_dr,
  input  logic            update_dr,
  input  logic            chain_tail,
  output logic            cell_mode,
  output logic            sel_boundary,
  output logic            bnd_capture,
  output logic            bnd_shift,
  output logic            bnd_update,
  output logic            dr_tdo
);
  import bscan_pkg::*;

  localparam logic [IR_W-1:0] CODE_EXTEST = '0;
  localparam logic [IR_W-1:0] CODE_SAMPLE = IR_W'(1);

  bscan_op_e op;
  logic      byp_q;

  bscan_op_decode #(
    .IR_W(IR_W), .CODE_EXTEST(CODE_EXTEST), .CODE_SAMPLE(CODE_SAMPLE)
  ) u_decode (
    .trst_n(trst_n), .ir_code(ir_code), .op(op)
  );

  assign cell_mode    = (op == OP_EXTEST);
  assign sel_boundary = (op != OP_BYPASS);

  bscan_bypass_stage u_bypass (
    .tck(tck), .trst_n(trst_n), .active(~sel_boundary), .tdi(tdi),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .q(byp_q)
  );

  bscan_strobe_gate u_gate (
    .sel_boundary(sel_boundary), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr),
    .bnd_capture(bnd_capture), .bnd_shift(bnd_shift), .bnd_update(bnd_update)
  );

  assign dr_tdo = sel_boundary ? chain_tail : byp_q;

  assert_mode_needs_chain_R1: assert property (@(posedge tck) disable iff (!trst_n)
    cell_mode |-> sel_boundary);
  assert_quiet_chain_R7: assert property (@(posedge tck) disable iff (!trst_n)
    !sel_boundary |-> (!bnd_capture && !bnd_shift && !bnd_update));
  assert_sample_no_drive_R9: assert property (@(posedge tck) disable iff (!trst_n)
    (ir_code == CODE_SAMPLE) |-> (!cell_mode && sel_boundary));
endmodule

// File: tb/bscan_instr_decoder_tb.sv
module bscan_instr_decoder_tb;
  localparam int CLK_PERIOD = 10;

  logic       tck = 1'b0;
  logic       trst_n = 1'b0;
  logic [1:0] ir_code = 2'b00;
  logic       tdi = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
  logic       chain_tail = 1'b0;
  logic       cell_mode, sel_boundary, bnd_capture, bnd_shift, bnd_update, dr_tdo;
  int         checks = 0, errors = 0;

  always #(CLK_PERIOD/2) tck = ~tck;

  bscan_instr_decoder u_dut (
    .tck(tck), .trst_n(trst_n), .ir_code(ir_code), .tdi(tdi),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .chain_tail(chain_tail), .cell_mode(cell_mode), .sel_boundary(sel_boundary),
    .bnd_capture(bnd_capture), .bnd_shift(bnd_shift), .bnd_update(bnd_update),
    .dr_tdo(dr_tdo)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    capture_dr = 0; shift_dr = 0; update_dr = 0;
  endtask

  // R2: reset forces bypass and clears the bypass stage
  task automatic t_reset();
    trst_n = 0; ir_code = 2'b00; capture_dr = 1; shift_dr = 1; update_dr = 1;
    #1;
    check("R2 ctrl", {cell_mode, sel_boundary, bnd_capture, bnd_shift, bnd_update}, 0);
    check("R2 tdo", dr_tdo, 0);
    idle();
    @(negedge tck); trst_n = 1;
    @(negedge tck);
  endtask

  // R1: code table
  task automatic t_decode();
    logic [1:0] exp_ms [4] = '{2'b11, 2'b01, 2'b00, 2'b00};
    for (int c = 0; c < 4; c++) begin
      @(negedge tck); ir_code = 2'(c); #1;
      check("R1", {cell_mode, sel_boundary}, exp_ms[c]);
    end
  endtask

  // R4: TDI to dr_tdo with one clock delay
  task automatic t_bypass_shift();
    logic [7:0] pat = 8'b1011_0010;
    @(negedge tck); ir_code = 2'b11;
    for (int i = 0; i < 8; i++) begin
      tdi = pat[i]; shift_dr = 1;
      @(negedge tck);
      check("R4", dr_tdo, pat[i]);
    end
    idle();
  endtask

  // R3, R5, R6: capture, priority, hold
  task automatic t_capture_hold();
    @(negedge tck); ir_code = 2'b10; tdi = 1; shift_dr = 1;
    @(negedge tck); check("R4 setup", dr_tdo, 1);
    shift_dr = 0; tdi = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge tck); check("R6", dr_tdo, 1);
    end
    capture_dr = 1;
    @(negedge tck); check("R3", dr_tdo, 0);
    idle(); tdi = 1; shift_dr = 1;
    @(negedge tck); check("R4 reload", dr_tdo, 1);
    capture_dr = 1; shift_dr = 1; tdi = 1;
    @(negedge tck); check("R5", dr_tdo, 0);
    idle();
  endtask

  // R7, R8: strobe gating and chain output
  task automatic t_boundary();
    for (int c = 0; c < 4; c++) begin
      for (int s = 0; s < 8; s++) begin
        @(negedge tck); ir_code = 2'(c);
        capture_dr = s[0]; shift_dr = s[1]; update_dr = s[2]; #1;
        check("R7", {bnd_capture, bnd_shift, bnd_update},
              (c < 2) ? {s[0], s[1], s[2]} : 3'b000);
      end
    end
    idle();
    @(negedge tck); ir_code = 2'b00;
    for (int i = 0; i < 4; i++) begin
      chain_tail = i[0]; #1; check("R8", dr_tdo, i[0]);
    end
    ir_code = 2'b01; chain_tail = 1; #1; check("R8 sample", dr_tdo, 1);
  endtask

  // R9: preload does not drive pins
  task automatic t_sample_update();
    @(negedge tck); ir_code = 2'b01; update_dr = 1; #1;
    check("R9", {bnd_update, cell_mode}, 2'b10);
    idle();
  endtask

  // R2: reset in mid-run clears a set bypass stage
  task automatic t_reset_mid();
    @(negedge tck); ir_code = 2'b11; tdi = 1; shift_dr = 1;
    @(negedge tck); idle(); check("R2 pre", dr_tdo, 1);
    trst_n = 0; ir_code = 2'b00; #1;
    check("R2 mid", {dr_tdo, cell_mode, sel_boundary}, 0);
    @(negedge tck); trst_n = 1;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_decode();
        t_bypass_shift();
        t_capture_hold();
        t_boundary();
        t_sample_update();
        t_reset_mid();
      end
      begin
        repeat (20000) @(posedge tck);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule